// File: doc/BRIEF.md
# Idle-Timeout Key Zeroisation Controller

This block keeps a secret wrapping key in flip-flops and erases it by itself once the key has sat unused for a number of clock cycles that software chooses. Software reaches it over a 32-bit register bus with an 8-bit word address. Through that bus it can:

- write the key word by word;
- commit the key, picking a 128-bit or 256-bit length;
- program the idle timeout;
- read a status word;
- order an immediate wipe.

The cipher datapath sees the key on a wide output, together with a valid flag and a length flag.

The idle counter only runs while a committed key is present. It holds its value while the datapath reports that an operation is in flight. It restarts from the programmed value in three cases: an operation completes, software commits a key, or software reads the status register. A program that wants to keep its key can therefore poll status regularly. When the count runs out, every key bit is cleared, the key-valid flag drops and an expired flag is raised. The expired flag stays set until the next commit. An explicit wipe command clears the key at once, whatever the counter holds.

Register map, with word addresses:

| Address | Register | Contents |
|---|---|---|
| 0x08 | control | bit 0 commit, bit 1 wipe, bit 2 select 256-bit; reads back bit 2 |
| 0x09 | status | bit 0 key loaded, bit 1 timeout expired |
| 0x0A | timeout | cycle count, read/write |
| 0x10 to 0x17 | key | key words 0 to 7; write-only |

Top module: `key_zeroize_ctrl`

## Requirements
- R1: Key word i written at address 0x10+i lands at key_out[255-32*i -: 32], so word 0 is most significant. Writing 1 to control bit 0 (address 0x08) sets key_valid and status bit 0 on the following cycle.
- R2: Control bit 2, captured at commit, selects the 256-bit length and drives key_is_256. When it is 0, key_out[127:0] is all zero and only words 0 to 3 appear in the upper half.
- R3: After a commit with timeout value T, T ≥ 1, and with no busy, completion or status read in between, key_valid is still 1 after T-1 more clock edges. After T edges key_valid is 0 and key_out is all zero.
- R4: Status bit 1 (address 0x09) becomes 1 when the idle count expires and returns to 0 at the next commit. Status bit 0 follows key_valid.
- R5: While op_busy is high, the idle count does not advance. On release, counting resumes from the value it held.
- R6: A one-cycle op_done pulse reloads the idle count with the programmed timeout.
- R7: A bus read of address 0x09 reloads the idle count. This reload wins over an expiry that would otherwise happen on the same edge.
- R8: Writing 1 to control bit 1 clears the key and key_valid on the next edge. This wipe wins over a simultaneous op_done, and it leaves status bit 1 at 0.
- R9: Reset, synchronous and active low, leaves key_valid 0, key_out 0, status 0 and key_is_256 0. The timeout register (address 0x0A) reads back 1000 after reset and reads back whatever value was last written.
- R10: Reads of the key addresses 0x10 to 0x17 always return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| op_busy | input | 1 | Cipher operation in progress |
| op_done | input | 1 | One-cycle pulse at end of operation |
| key_out | output | 256 | Key material, word 0 most significant |
| key_valid | output | 1 | A committed key is present |
| key_is_256 | output | 1 | Committed key length is 256 bits |

## Verification
The assertions assume that a bus access lasts exactly one cycle. They also assume that op_done is a single-cycle pulse, and that a status read and a control write never share a cycle, which the single bus port already guarantees. The bench drives every bus access as a one-cycle strobe from a negative clock edge and pulses op_done for exactly one cycle. The one deliberate overlap it creates is op_done arriving together with a wipe write, which is the ordering covered by R8.

// File: rtl/kz_pkg.sv
// Package: shared register addresses, control/status bit positions and the
// decoded-command type used between the bus decoder and the state logic.
package kz_pkg;
    localparam int          ADDR_W     = 8;
    localparam logic [7:0]  A_CTRL     = 8'h08;
    localparam logic [7:0]  A_STATUS   = 8'h09;
    localparam logic [7:0]  A_TIMEOUT  = 8'h0A;
    localparam logic [7:0]  A_KEY_BASE = 8'h10;

    localparam int CB_COMMIT = 0;
    localparam int CB_WIPE   = 1;
    localparam int CB_LEN256 = 2;

    localparam int SB_LOADED  = 0;
    localparam int SB_EXPIRED = 1;

    typedef struct packed {
        logic commit;
        logic wipe;
        logic len256;
        logic tmo_we;
        logic key_we;
        logic status_rd;
    } kz_cmd_t;
endpackage

// File: rtl/kz_bus_decode.sv
// Module: kz_bus_decode
// Turns a one-cycle bus access into command strobes and builds read data.
// Assumes each access is a single-cycle strobe; key words are never readable.
module kz_bus_decode
    import kz_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int CNT_W     = 32,
    localparam int IDX_W    = $clog2(KEY_WORDS)
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              loaded,
    input  logic              expired,
    input  logic              len256,
    input  logic [CNT_W-1:0]  tmo,
    output kz_cmd_t           cmd,
    output logic [IDX_W-1:0]  key_idx,
    output logic [WORD_W-1:0] rdata
);
    logic             in_key;
    logic [ADDR_W-1:0] key_off;

    // Key window hit test and offset into it.
    always_comb begin
        key_off = addr - A_KEY_BASE;
        in_key  = (addr >= A_KEY_BASE) &&
                  (addr < A_KEY_BASE + ADDR_W'(KEY_WORDS));
        key_idx = key_off[IDX_W-1:0];
    end

    // Command strobes from the write or read access.
    always_comb begin
        cmd           = '0;
        cmd.commit    = cs && we && (addr == A_CTRL) && wdata[CB_COMMIT];
        cmd.wipe      = cs && we && (addr == A_CTRL) && wdata[CB_WIPE];
        cmd.len256    = wdata[CB_LEN256];
        cmd.tmo_we    = cs && we && (addr == A_TIMEOUT);
        cmd.key_we    = cs && we && in_key;
        cmd.status_rd = cs && !we && (addr == A_STATUS);
    end

    // Read data multiplexer; key addresses fall to the zero default.
    always_comb begin
        rdata = '0;
        if (cs && !we) begin
            unique case (addr)
                A_CTRL:    rdata[CB_LEN256] = len256;
                A_STATUS:  begin
                    rdata[SB_LOADED]  = loaded;
                    rdata[SB_EXPIRED] = expired;
                end
                A_TIMEOUT: rdata = WORD_W'(tmo);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/kz_key_store.sv
// Module: kz_key_store
// Holds the key as KEY_WORDS registers, word 0 most significant, plus the
// length select. A wipe clears every key bit and beats a same-cycle word write.
// In short mode the lower half of the output is forced to zero.
module kz_key_store #(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    localparam int KEY_W    = WORD_W * KEY_WORDS,
    localparam int IDX_W    = $clog2(KEY_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              word_we,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              len_we,
    input  logic              len_val,
    output logic [KEY_W-1:0]  key,
    output logic              len256
);
    logic [KEY_W-1:0] key_q;

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_word
        localparam int TOP = KEY_W - 1 - i * WORD_W;
        // Word i storage: cleared by reset or wipe, loaded on its write.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                key_q[TOP -: WORD_W] <= '0;
            else if (word_we && word_idx == IDX_W'(i))
                key_q[TOP -: WORD_W] <= wdata;
        end
    end

    // Length select captured at commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      len256 <= 1'b0;
        else if (len_we) len256 <= len_val;
    end

    // Output: the lower half is shown only in long mode.
    always_comb begin
        key = key_q;
        if (!len256) key[KEY_W/2-1:0] = '0;
    end
endmodule

// File: rtl/kz_idle_timer.sv
// Module: kz_idle_timer
// Timeout register, idle down-counter and loaded/expired flags.
// Priority per edge: wipe, commit, reload (done or status read), countdown.
// Counting happens only while loaded and not busy. A count of 1 or 0 expires.
module kz_idle_timer #(
    parameter int         CNT_W    = 32,
    parameter logic [31:0] TMO_INIT = 32'd1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_we,
    input  logic [CNT_W-1:0] tmo_wdata,
    input  logic             wipe_cmd,
    input  logic             commit,
    input  logic             reload,
    input  logic             busy,
    output logic [CNT_W-1:0] tmo,
    output logic [CNT_W-1:0] cnt,
    output logic             loaded,
    output logic             expired,
    output logic             expire_now
);
    // Expiry strobe: the count runs out this cycle with nothing overriding it.
    always_comb begin
        expire_now = loaded && !busy && !wipe_cmd && !commit && !reload &&
                     (cnt <= CNT_W'(1));
    end

    // Programmable timeout register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tmo <= CNT_W'(TMO_INIT);
        else if (tmo_we) tmo <= tmo_wdata;
    end

    // Counter and flags, updated in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            loaded  <= 1'b0;
            expired <= 1'b0;
        end else if (wipe_cmd) begin
            cnt    <= '0;
            loaded <= 1'b0;
        end else if (commit) begin
            cnt     <= tmo;
            loaded  <= 1'b1;
            expired <= 1'b0;
        end else if (reload) begin
            cnt <= tmo;
        end else if (expire_now) begin
            cnt     <= '0;
            loaded  <= 1'b0;
            expired <= 1'b1;
        end else if (loaded && !busy) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/key_zeroize_ctrl.sv
// Module: key_zeroize_ctrl (top)
// Key register bank with automatic wipe after a programmable idle period.
// Assumes single-cycle bus strobes and a single-cycle op_done pulse.
module key_zeroize_ctrl
    import kz_pkg::*;
#(
    parameter int          WORD_W    = 32,
    parameter int          KEY_WORDS = 8,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] TMO_INIT  = 32'd1000,
    localparam int         KEY_W     = WORD_W * KEY_WORDS,
    localparam int         IDX_W     = $clog2(KEY_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              op_busy,
    input  logic              op_done,
    output logic [KEY_W-1:0]  key_out,
    output logic              key_valid,
    output logic              key_is_256
);
    kz_cmd_t          cmd;
    logic [IDX_W-1:0] key_idx;
    logic [CNT_W-1:0] tmo_val;
    logic [CNT_W-1:0] idle_cnt;
    logic             expired;
    logic             expire_now;
    logic             wipe_all;

    // Either cause of a wipe clears the key registers.
    always_comb wipe_all = cmd.wipe || expire_now;

    kz_bus_decode #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .CNT_W(CNT_W)) u_dec (
        .cs(bus_cs), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .loaded(key_valid), .expired(expired), .len256(key_is_256),
        .tmo(tmo_val), .cmd(cmd), .key_idx(key_idx), .rdata(bus_rdata)
    );

    kz_key_store #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .wipe(wipe_all),
        .word_we(cmd.key_we), .word_idx(key_idx), .wdata(bus_wdata),
        .len_we(cmd.commit && !cmd.wipe), .len_val(cmd.len256),
        .key(key_out), .len256(key_is_256)
    );

    kz_idle_timer #(.CNT_W(CNT_W), .TMO_INIT(TMO_INIT)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .tmo_we(cmd.tmo_we), .tmo_wdata(bus_wdata[CNT_W-1:0]),
        .wipe_cmd(cmd.wipe), .commit(cmd.commit),
        .reload(op_done || cmd.status_rd), .busy(op_busy),
        .tmo(tmo_val), .cnt(idle_cnt), .loaded(key_valid),
        .expired(expired), .expire_now(expire_now)
    );
endmodule

// File: rtl/kz_checker.sv
// Module: kz_checker
// Temporal properties of the zeroisation controller, bound to the top.
// Assumes single-cycle bus strobes, so a status read never shares a cycle
// with a control write.
module kz_checker #(
    parameter int KEY_W = 256,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_valid,
    input logic             expired,
    input logic [KEY_W-1:0] key_out,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tmo,
    input logic             busy,
    input logic             done,
    input logic             status_rd,
    input logic             wipe_cmd,
    input logic             commit
);
    AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_cmd |=> (!key_valid && key_out == '0)); // R8

    AST_EXPIRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !busy && !done && !status_rd && !wipe_cmd && !commit &&
         cnt == CNT_W'(1)) |=> (!key_valid && expired && key_out == '0)); // R3

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && busy && !done && !status_rd && !wipe_cmd && !commit)
        |=> $stable(cnt)); // R5

    AST_DONE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wipe_cmd && !commit) |=> (cnt == $past(tmo))); // R6

    AST_STATUS_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && key_valid) |=> (key_valid && cnt == $past(tmo))); // R7

    AST_COMMIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wipe_cmd) |=> (key_valid && !expired)); // R1
endmodule

bind key_zeroize_ctrl kz_checker #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .expired(expired),
    .key_out(key_out), .cnt(idle_cnt), .tmo(tmo_val), .busy(op_busy),
    .done(op_done), .status_rd(cmd.status_rd), .wipe_cmd(cmd.wipe),
    .commit(cmd.commit)
);

// File: tb/key_zeroize_ctrl_test.sv
// Bench: directed scenarios, one task each, checking results at negedges.
module key_zeroize_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_cs = 1'b0, bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         op_busy = 1'b0, op_done = 1'b0;
    logic [255:0] key_out;
    logic         key_valid, key_is_256;
    int           n_chk = 0, n_fail = 0;
    logic [31:0]  rd;

    always #5 clk = ~clk;

    key_zeroize_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .op_busy(op_busy), .op_done(op_done), .key_out(key_out),
        .key_valid(key_valid), .key_is_256(key_is_256)
    );

    function automatic logic [31:0] kw(int i);
        return 32'hC0DE0000 + 32'h01010101 * i;
    endfunction

    function automatic logic [255:0] full_key();
        logic [255:0] k;
        for (int i = 0; i < 8; i++) k[255 - 32*i -: 32] = kw(i);
        return k;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end on a negedge; the access takes one edge.
    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_we = 0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_cs = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_cs = 0;
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_key(logic long_key);
        for (int i = 0; i < 8; i++) bus_write(8'h10 + 8'(i), kw(i));
        bus_write(8'h08, long_key ? 32'h5 : 32'h1);
    endtask

    task automatic t_reset();
        check("R9 valid", 256'(key_valid), 256'(0));
        check("R9 key", key_out, 256'(0));
        check("R9 len", 256'(key_is_256), 256'(0));
        bus_read(8'h09, rd); check("R9 status", 256'(rd), 256'(0));
        bus_read(8'h0A, rd); check("R9 tmo default", 256'(rd), 256'(1000));
    endtask

    task automatic t_load_long();
        load_key(1'b1);
        check("R1 valid", 256'(key_valid), 256'(1));
        check("R1 key order", key_out, full_key());
        check("R2 len256", 256'(key_is_256), 256'(1));
        bus_read(8'h09, rd); check("R1 status loaded", 256'(rd), 256'(1));
        bus_read(8'h13, rd); check("R10 key unreadable", 256'(rd), 256'(0));
    endtask

    task automatic t_load_short();
        logic [255:0] e;
        e = full_key(); e[127:0] = '0;
        load_key(1'b0);
        check("R2 short key", key_out, e);
        check("R2 len flag", 256'(key_is_256), 256'(0));
    endtask

    task automatic t_expiry();
        bus_write(8'h0A, 32'd20);
        bus_read(8'h0A, rd); check("R9 tmo readback", 256'(rd), 256'(20));
        load_key(1'b1);
        edges(19); check("R3 alive at T-1", 256'(key_valid), 256'(1));
        edges(1);  check("R3 gone at T", 256'(key_valid), 256'(0));
        check("R3 key wiped", key_out, 256'(0));
        bus_read(8'h09, rd); check("R4 expired flag", 256'(rd), 256'(2));
        load_key(1'b1);
        bus_read(8'h09, rd); check("R4 cleared by commit", 256'(rd), 256'(1));
        edges(30);
    endtask

    task automatic t_busy();
        load_key(1'b1);
        edges(5);
        op_busy = 1; edges(50); op_busy = 0;
        check("R5 frozen while busy", 256'(key_valid), 256'(1));
        edges(14); check("R5 resume alive", 256'(key_valid), 256'(1));
        edges(1);  check("R5 resume expire", 256'(key_valid), 256'(0));
    endtask

    task automatic t_done();
        load_key(1'b1);
        edges(15);
        op_done = 1; edges(1); op_done = 0;
        edges(19); check("R6 reload alive", 256'(key_valid), 256'(1));
        edges(1);  check("R6 reload expire", 256'(key_valid), 256'(0));
    endtask

    task automatic t_status_keepalive();
        load_key(1'b1);
        edges(19);
        bus_read(8'h09, rd);
        check("R7 read beats expiry", 256'(key_valid), 256'(1));
        edges(19); check("R7 reload alive", 256'(key_valid), 256'(1));
        edges(1);  check("R7 reload expire", 256'(key_valid), 256'(0));
    endtask

    task automatic t_wipe();
        bus_write(8'h0A, 32'd1000);
        load_key(1'b1);
        op_done = 1;
        bus_write(8'h08, 32'h2);
        op_done = 0;
        check("R8 wipe valid", 256'(key_valid), 256'(0));
        check("R8 wipe key", key_out, 256'(0));
        bus_read(8'h09, rd); check("R8 no expired flag", 256'(rd), 256'(0));
    endtask

    initial begin
        edges(3);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_long();
        t_load_short();
        t_expiry();
        t_busy();
        t_done();
        t_status_keepalive();
        t_wipe();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule